// File: doc/BRIEF.md
# Unaligned Streaming Predicate Store Buffer

This block takes a stream of 64-bit predicate words. Each word carries its own start byte address, and that address may have any byte alignment. The block writes the words into scratch memory as aligned 64-bit words with per-byte write strobes. When an incoming word is unaligned, it straddles two memory words. The part that falls in the lower memory word goes out at once. The upper part (the tail) is kept in a one-word buffer. The tail is merged with the next store when that store lands in the same memory word. It is written out alone when the next store lands elsewhere or when a flush request arrives. Because of this buffering, one predicate word may reach memory in pieces and at different times.

The block keeps an alignment-base register. It is zero after reset and before the first store. After each accepted store it becomes the low three bits of the byte address just past the last stored byte, and an update pulse marks each change. The memory side has one write port: a single-cycle write enable, a word address, data and byte strobes. The input side uses a valid/ready handshake. The block drops ready for exactly one cycle when a store forces two memory writes.

Top module: `predstream_store_buf`

## Requirements
- R1: After reset, in_ready is 1, mem_we is 0, align_base is 0 and align_upd is 0.
- R2: A store whose address has low three bits 0, made while no tail is held, produces one write in the cycle after acceptance. That write has word address in_addr[ADDR_W-1:3], strobe 8'hFF and data equal to in_data. No tail is kept.
- R3: Byte j of in_data (bits 8j+7..8j) is destined for byte address in_addr+j (wrapping at ADDR_W bits). It goes to lane (in_addr+j) mod 8 of word (in_addr+j)>>3. Lanes in the store's first word are written at once. Lanes in the following word are held as a tail, which always starts at lane 0 and never includes lane 7.
- R4: If a tail is held for the same word as the first word of a new store, one write is issued. Its strobe is the union of both, and the new store's bytes win where the two overlap.
- R5: If a tail is held for a different word than the first word of a new store, the tail is written in the cycle after acceptance and the new store's first word in the cycle after that. in_ready is 0 for exactly that one cycle in between.
- R6: A flush is taken in a cycle with flush=1, in_ready=1 and in_valid=0. If a tail is held, it is written in the next cycle and the buffer becomes empty. If the buffer is empty, no write is issued.
- R7: A flush asserted together with in_valid=1 is ignored. The store is taken normally and its tail stays held.
- R8: align_base is 0 until the first store. In the cycle after each accepted store, align_upd is 1 and align_base equals (in_addr+8) mod 8. In every other cycle, align_upd is 0 and align_base is unchanged.
- R9: Byte lanes of mem_wdata whose strobe bit is 0 are zero.
- R10: Every write appears in exactly the cycle stated in R2 to R6, and writes reach memory in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Store request valid |
| in_ready | output | 1 | Store can be accepted this cycle |
| in_data | input | 64 | Predicate word, byte j at address in_addr+j |
| in_addr | input | ADDR_W | Start byte address in scratch memory, any alignment |
| flush | input | 1 | Request to write out any held tail |
| mem_we | output | 1 | Memory write enable, one cycle per write |
| mem_waddr | output | ADDR_W-3 | Aligned 64-bit word address |
| mem_wdata | output | 64 | Write data, lane k in bits 8k+7..8k |
| mem_strb | output | 8 | Byte write strobes |
| align_base | output | 3 | Current alignment base |
| align_upd | output | 1 | Pulse marking an alignment-base update |

## Verification
A corrupted tail register stays hidden until the next store lands in its word or a flush arrives. At that point it appears as wrong lanes, a wrong strobe or a wrong word address on the memory port. A tail that goes missing shows up when a flush issues no write at all. Each observed write is therefore compared against a byte-level reference, together with the exact cycle in which it was due. Flushes are mixed into the random stream so that held state surfaces within a few cycles rather than only at the end. A wrong alignment base is visible in the cycle right after the store that set it.

// File: rtl/pstb_pkg.sv
`timescale 1ns/1ps
package pstb_pkg;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned WORD_BITS  = WORD_BYTES * 8;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);

  typedef logic [WORD_BYTES-1:0] strb_t;
  typedef logic [WORD_BITS-1:0]  word_t;
  typedef logic [OFF_W-1:0]      off_t;

  // Expand byte strobes into a bit mask.
  function automatic word_t lane_mask(strb_t s);
    word_t m;
    m = '0;
    for (int b = 0; b < int'(WORD_BYTES); b++) begin
      if (s[b]) m[8*b +: 8] = 8'hFF;
    end
    return m;
  endfunction

  // Overlay new lanes onto old ones; new lanes win.
  function automatic word_t merge_lanes(word_t old_d, word_t new_d, strb_t new_s);
    word_t m;
    m = lane_mask(new_s);
    return (old_d & ~m) | (new_d & m);
  endfunction

  // Alignment base after a full-word store starting at offset off.
  function automatic off_t next_align(off_t off);
    logic [OFF_W:0] sum;
    sum = {1'b0, off} + (OFF_W+1)'(WORD_BYTES);
    return sum[OFF_W-1:0];
  endfunction
endpackage

// File: rtl/pstb_lane_split.sv
`timescale 1ns/1ps
module pstb_lane_split
  import pstb_pkg::*;
(
  input  word_t data,
  input  off_t  off,
  output word_t lo_data,
  output strb_t lo_strb,
  output word_t hi_data,
  output strb_t hi_strb,
  output logic  has_tail
);
  // Each lane takes input byte (lane - off) mod WORD_BYTES; lanes at or
  // above the offset belong to the first word, the rest to the tail.
  for (genvar b = 0; b < int'(WORD_BYTES); b++) begin : g_lane
    off_t       src;
    logic [7:0] byte_v;
    logic       in_lo;
    always_comb begin
      src    = off_t'(b) - off;
      byte_v = data[8*src +: 8];
      in_lo  = (off <= off_t'(b));
    end
    assign lo_strb[b]        = in_lo;
    assign hi_strb[b]        = ~in_lo;
    assign lo_data[8*b +: 8] = in_lo ? byte_v : 8'h00;
    assign hi_data[8*b +: 8] = in_lo ? 8'h00 : byte_v;
  end

  assign has_tail = (off != '0);
endmodule

// File: rtl/pstb_tail_buf.sv
`timescale 1ns/1ps
module pstb_tail_buf
  import pstb_pkg::*;
#(
  parameter int unsigned WADDR_W = 13
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic               nxt_valid,
  input  logic [WADDR_W-1:0] nxt_waddr,
  input  word_t              nxt_data,
  input  strb_t              nxt_strb,
  output logic               pend_valid,
  output logic [WADDR_W-1:0] pend_waddr,
  output word_t              pend_data,
  output strb_t              pend_strb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_waddr <= '0;
      pend_data  <= '0;
      pend_strb  <= '0;
    end else if (upd) begin
      pend_valid <= nxt_valid;
      pend_waddr <= nxt_waddr;
      pend_data  <= nxt_valid ? nxt_data : '0;
      pend_strb  <= nxt_valid ? nxt_strb : '0;
    end
  end

  // R3: a held tail starts at lane 0 and never fills the top lane
  a_r3_tail_shape: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_strb[0] && !pend_strb[WORD_BYTES-1]));
  // R9: lanes outside the held strobe stay zero
  a_r9_tail_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_data & ~lane_mask(pend_strb)) == '0);
endmodule

// File: rtl/pstb_write_seq.sv
`timescale 1ns/1ps
module pstb_write_seq
  import pstb_pkg::*;
#(
  parameter int unsigned WADDR_W = 13
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [WADDR_W-1:0] a_waddr,
  input  word_t              a_data,
  input  strb_t              a_strb,
  input  logic               b_valid,
  input  logic [WADDR_W-1:0] b_waddr,
  input  word_t              b_data,
  input  strb_t              b_strb,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_waddr,
  output word_t              mem_wdata,
  output strb_t              mem_strb,
  output logic               busy
);
  logic               sp_v;
  logic [WADDR_W-1:0] sp_w;
  word_t              sp_d;
  strb_t              sp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      mem_strb  <= '0;
      sp_v      <= 1'b0;
      sp_w      <= '0;
      sp_d      <= '0;
      sp_s      <= '0;
    end else if (sp_v) begin
      mem_we    <= 1'b1;
      mem_waddr <= sp_w;
      mem_wdata <= sp_d;
      mem_strb  <= sp_s;
      sp_v      <= 1'b0;
    end else if (issue) begin
      mem_we    <= 1'b1;
      mem_waddr <= a_waddr;
      mem_wdata <= a_data;
      mem_strb  <= a_strb;
      sp_v      <= b_valid;
      sp_w      <= b_waddr;
      sp_d      <= b_data;
      sp_s      <= b_strb;
    end else begin
      mem_we    <= 1'b0;
    end
  end

  assign busy = sp_v;

  // R5: the stall lasts one cycle and the queued write follows at once
  a_r5_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  a_r5_spill_follows: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> mem_we);
  // R10: an issued write reaches the port in the next cycle
  a_r10_prompt_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy) |=> mem_we);
  // R9: unstrobed lanes are zero and a write always has a strobe
  a_r9_quiet_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (((mem_wdata & ~lane_mask(mem_strb)) == '0) && (mem_strb != '0)));
endmodule

// File: rtl/pstb_align_track.sv
`timescale 1ns/1ps
module pstb_align_track
  import pstb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  off_t off,
  output off_t align_base,
  output logic align_upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_base <= '0;
      align_upd  <= 1'b0;
    end else begin
      align_upd <= upd;
      if (upd) align_base <= next_align(off);
    end
  end

  // R8: an update pulse follows every store; otherwise the base holds
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> align_upd);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> (!align_upd && $stable(align_base)));
endmodule

// File: rtl/predstream_store_buf.sv
`timescale 1ns/1ps
module predstream_store_buf
  import pstb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_data,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              flush,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_waddr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_strb,
  output logic [2:0]        align_base,
  output logic              align_upd
);
  localparam int unsigned WADDR_W = ADDR_W - OFF_W;

  // Named internal events
  logic               accept, flush_go, busy;
  logic               same_word, evict;
  off_t               off;
  logic [WADDR_W-1:0] waddr;

  word_t lo_data, hi_data;
  strb_t lo_strb, hi_strb;
  logic  has_tail;

  logic               pend_valid;
  logic [WADDR_W-1:0] pend_waddr;
  word_t              pend_data;
  strb_t              pend_strb;

  logic               issue, b_valid;
  logic [WADDR_W-1:0] a_waddr;
  word_t              a_data;
  strb_t              a_strb;

  assign in_ready  = ~busy;
  assign accept    = in_valid & in_ready;
  assign flush_go  = flush & in_ready & ~in_valid;
  assign off       = in_addr[OFF_W-1:0];
  assign waddr     = in_addr[ADDR_W-1:OFF_W];
  assign same_word = pend_valid && (pend_waddr == waddr);
  assign evict     = pend_valid && !same_word;

  pstb_lane_split u_split (
    .data     (in_data),
    .off      (off),
    .lo_data  (lo_data),
    .lo_strb  (lo_strb),
    .hi_data  (hi_data),
    .hi_strb  (hi_strb),
    .has_tail (has_tail)
  );

  pstb_tail_buf #(.WADDR_W(WADDR_W)) u_tail (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (accept | flush_go),
    .nxt_valid  (accept & has_tail),
    .nxt_waddr  (waddr + WADDR_W'(1)),
    .nxt_data   (hi_data),
    .nxt_strb   (hi_strb),
    .pend_valid (pend_valid),
    .pend_waddr (pend_waddr),
    .pend_data  (pend_data),
    .pend_strb  (pend_strb)
  );

  // First write of the cycle: held tail (evict or flush), merged word, or
  // the store's own first word.
  always_comb begin
    issue   = accept | (flush_go & pend_valid);
    b_valid = accept & evict;
    if (!accept || evict) begin
      a_waddr = pend_waddr;
      a_data  = pend_data;
      a_strb  = pend_strb;
    end else if (same_word) begin
      a_waddr = waddr;
      a_data  = merge_lanes(pend_data, lo_data, lo_strb);
      a_strb  = pend_strb | lo_strb;
    end else begin
      a_waddr = waddr;
      a_data  = lo_data;
      a_strb  = lo_strb;
    end
  end

  pstb_write_seq #(.WADDR_W(WADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .a_waddr   (a_waddr),
    .a_data    (a_data),
    .a_strb    (a_strb),
    .b_valid   (b_valid),
    .b_waddr   (waddr),
    .b_data    (lo_data),
    .b_strb    (lo_strb),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_strb  (mem_strb),
    .busy      (busy)
  );

  pstb_align_track u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (accept),
    .off        (off),
    .align_base (align_base),
    .align_upd  (align_upd)
  );

  // R6: flushing an empty buffer writes nothing; any flush empties it
  a_r6_empty_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && !pend_valid) |=> !mem_we);
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |=> !pend_valid);
  // R7: flush alongside a store leaves the new tail held
  a_r7_flush_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flush && (off != '0)) |=> pend_valid);
  // R5: an evicting store stalls the input for the following cycle
  a_r5_evict_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && evict) |=> !in_ready);
endmodule

// File: tb/predstream_store_buf_tb.sv
`timescale 1ns/1ps
module predstream_store_buf_tb;
  localparam int AW  = 16;
  localparam int WAW = AW - 3;

  typedef struct packed {
    logic [WAW-1:0] w;
    logic [63:0]    d;
    logic [7:0]     s;
    logic [31:0]    due;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n, in_valid, in_ready, flush;
  logic [63:0]    in_data;
  logic [AW-1:0]  in_addr;
  logic           mem_we, align_upd;
  logic [WAW-1:0] mem_waddr;
  logic [63:0]    mem_wdata;
  logic [7:0]     mem_strb;
  logic [2:0]     align_base;

  predstream_store_buf #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_addr(in_addr), .flush(flush),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_strb(mem_strb), .align_base(align_base), .align_upd(align_upd)
  );

  int unsigned checks = 0, errors = 0;
  logic [31:0] cyc = 0;
  bit done = 0;
  exp_t expq[$];

  // Reference model state
  bit             pm_v = 0;
  logic [WAW-1:0] pm_w = '0;
  logic [7:0]     pm_s = '0;
  logic [63:0]    pm_d = '0;
  logic [2:0]     exp_base = '0;
  bit             exp_upd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic push(logic [WAW-1:0] w, logic [63:0] d, logic [7:0] s, logic [31:0] due);
    exp_t e;
    e.w = w; e.d = d; e.s = s; e.due = due;
    expq.push_back(e);
  endtask

  // Byte-address model: byte j goes to address addr+j.
  task automatic model_store(logic [AW-1:0] addr, logic [63:0] data);
    logic [63:0]    ld = '0, td = '0;
    logic [7:0]     ls = '0, ts = '0;
    logic [WAW-1:0] w0 = addr[AW-1:3];
    logic [WAW-1:0] w1 = w0;
    logic [AW-1:0]  endp;
    for (int j = 0; j < 8; j++) begin
      logic [AW-1:0] a;
      a = AW'(addr + AW'(j));
      if (a[AW-1:3] == w0) begin
        ls[a[2:0]] = 1'b1;
        ld[8*a[2:0] +: 8] = data[8*j +: 8];
      end else begin
        ts[a[2:0]] = 1'b1;
        td[8*a[2:0] +: 8] = data[8*j +: 8];
        w1 = a[AW-1:3];
      end
    end
    if (pm_v && pm_w == w0) begin
      logic [63:0] md;
      md = pm_d;
      for (int k = 0; k < 8; k++) if (ls[k]) md[8*k +: 8] = ld[8*k +: 8];
      push(w0, md, pm_s | ls, cyc + 1);
    end else if (pm_v) begin
      push(pm_w, pm_d, pm_s, cyc + 1);
      push(w0, ld, ls, cyc + 2);
    end else begin
      push(w0, ld, ls, cyc + 1);
    end
    pm_v = (ts != 0); pm_w = w1; pm_s = ts; pm_d = td;
    endp = AW'(addr + AW'(8));
    exp_base = endp[2:0];
    exp_upd = 1;
  endtask

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic do_store(logic [AW-1:0] addr, logic [63:0] data, bit with_flush);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_addr = addr; in_data = data; flush = with_flush;
    model_store(addr, data);
    @(negedge clk);
    in_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    while (!in_ready) @(negedge clk);
    flush = 1;
    if (pm_v) begin
      push(pm_w, pm_d, pm_s, cyc + 1);
      pm_v = 0; pm_s = '0; pm_d = '0;
    end
    @(negedge clk);
    flush = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: sample shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (mem_we) begin
        if (expq.size() == 0) begin
          check(0, "R6", "unexpected write addr", 64'(mem_waddr), 64'hX);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(mem_waddr == e.w, "R3", "write word address", 64'(mem_waddr), 64'(e.w));
          check(mem_strb == e.s, "R4", "write strobe", 64'(mem_strb), 64'(e.s));
          check(mem_wdata == e.d, "R9", "write data", mem_wdata, e.d);
          check(cyc == e.due, "R10", "write cycle", 64'(cyc), 64'(e.due));
        end
      end else if (expq.size() != 0 && expq[0].due <= cyc) begin
        check(0, "R10", "missing write due", 64'(cyc), 64'(expq[0].due));
        void'(expq.pop_front());
      end
      if (exp_upd) begin
        check(align_upd == 1'b1, "R8", "align_upd pulse", 64'(align_upd), 64'd1);
        check(align_base == exp_base, "R8", "align_base", 64'(align_base), 64'(exp_base));
        exp_upd = 0;
      end else if (align_upd) begin
        check(0, "R8", "spurious align_upd", 64'(align_upd), 64'd0);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] prev;
    void'($urandom(32'd4242));
    rst_n = 0; in_valid = 0; flush = 0; in_data = '0; in_addr = '0;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1: reset state
    check(in_ready == 1'b1, "R1", "in_ready", 64'(in_ready), 64'd1);
    check(mem_we == 1'b0, "R1", "mem_we", 64'(mem_we), 64'd0);
    check(align_base == 3'd0, "R1", "align_base", 64'(align_base), 64'd0);
    check(align_upd == 1'b0, "R1", "align_upd", 64'(align_upd), 64'd0);

    // R2: aligned store, then R6 flush of an empty buffer
    do_store(16'h0040, 64'h0807060504030201, 0);
    idle(1);
    do_flush();
    check(mem_we == 1'b0, "R6", "empty flush write", 64'(mem_we), 64'd0);

    // R3: unaligned store; tail appears only on flush (R6)
    do_store(16'h0043, 64'h8877665544332211, 0);
    idle(3);
    do_flush();
    check(mem_we == 1'b1, "R6", "tail flush write", 64'(mem_we), 64'd1);
    idle(1);

    // R4: contiguous stream merges tails
    do_store(16'h0105, 64'h1111111111111111, 0);
    do_store(16'h010D, 64'h2222222222222222, 0);
    do_store(16'h0115, 64'h3333333333333333, 0);
    do_flush();
    idle(2);

    // R5: evicting store stalls the input one cycle
    do_store(16'h0203, 64'hA1A2A3A4A5A6A7A8, 0);
    do_store(16'h0300, 64'hB1B2B3B4B5B6B7B8, 0);
    check(in_ready == 1'b0, "R5", "stall after evict", 64'(in_ready), 64'd0);
    idle(1);
    check(in_ready == 1'b1, "R5", "ready after stall", 64'(in_ready), 64'd1);

    // R7: flush together with a store is ignored; tail still held
    do_store(16'h0401, 64'hC0C1C2C3C4C5C6C7, 1);
    idle(4);
    check(expq.size() == 0, "R7", "no tail write yet", 64'(expq.size()), 64'd0);
    do_flush();
    idle(2);

    // R3: address wrap at the top of the space
    do_store(16'hFFFD, 64'hDEADBEEFCAFEF00D, 0);
    do_flush();
    idle(2);

    // Random mix: mostly streaming, some jumps, flushes and pauses
    prev = 16'h0800;
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 8) begin
        do_flush();
      end else if (r < 13) begin
        idle(1);
      end else begin
        logic [AW-1:0] a;
        a = (r < 75) ? AW'(prev + 16'd8) : AW'($urandom & 32'h0FFF);
        if (r > 95) a = AW'(prev + AW'($urandom % 16));
        do_store(a, {$urandom, $urandom}, (r == 50));
        prev = a;
      end
    end
    do_flush();
    idle(4);
    check(expq.size() == 0, "R10", "all writes seen", 64'(expq.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule